// File: doc/BRIEF.md
# Timer-Gated Interrupt Enable Register

This block holds one CPU-writable enable byte and turns it into four interrupt request lines. One bit is a master switch. Four other bits enable individual request levels. Two of these levels are timer levels, and each also needs a limit-reached flag from its own pair of timer counters before it can assert. The other two levels are software levels, which assert as soon as the master bit and their own enable bit are both set. The counters are outside the block. Their limit flags arrive as plain inputs.

The request lines are registered. When a write is presented, the stored byte and all four request lines take their new values at the same clock edge. This means that toggling the master bit re-evaluates every level in one step, while writing an individual enable bit affects only its own level. A change on a limit flag reaches the lines one clock later, with no write needed, so a counter being cleared elsewhere withdraws its level by itself. The stored byte, including the bits that drive nothing, can always be read back.

Top module: `tmr_irq_enable`

## Requirements
- R1: Reset clears the stored byte to 0x00 and drives all four request lines low.
- R2: `rd_data` always returns the full stored byte, including bits 1, 4 and 6, which drive no output.
- R3: While bit 0 (the master switch) of the stored byte is 0, all four request lines are low, whatever the other bits and the limit flags are.
- R4: `irq_l14` is high exactly when bit 0 is set, bit 7 is set, and at least one of `tmr_flag[3]` and `tmr_flag[2]` is set.
- R5: `irq_l10` is high exactly when bit 0 is set, bit 5 is set, and at least one of `tmr_flag[1]` and `tmr_flag[0]` is set.
- R6: `irq_l6` is high exactly when bits 0 and 3 are both set. The limit flags have no effect on it.
- R7: `irq_soft` is high exactly when bits 0 and 2 are both set. The limit flags have no effect on it.
- R8: When `wr_en` is high at a rising edge, `wr_data` is stored at that edge, and the request lines show the levels computed from the new byte immediately after that same edge.
- R9: A change on `tmr_flag` with no write reaches the timer request lines at the next rising edge. Clearing the last set flag of a pair drops its level.
- R10: Bits 1, 4 and 6 have no effect on any request line.
- R11: With no write and unchanged limit flags, every request line holds its value. Rewriting the stored value leaves all lines steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the enable byte |
| wr_data | input | 8 | Byte to store |
| tmr_flag | input | 4 | Limit-reached flags of counters 3..0 |
| rd_data | output | 8 | Stored enable byte |
| irq_l14 | output | 1 | Level-14 timer request (counters 2 and 3) |
| irq_l10 | output | 1 | Level-10 timer request (counters 0 and 1) |
| irq_l6 | output | 1 | Level-6 software request |
| irq_soft | output | 1 | Lower-level software request |

## Verification
Two events can fall in the same cycle: a CPU write to the enable byte and a change on a counter limit flag. In that case, the edge must combine the new byte with the flags present at that edge. Several table rows therefore change the byte and the flags together. The most telling are a write that turns the master on while every flag is set, and a write that drops the master while flags are still set. For each such row, the bench compares all four lines and the readback against values worked out from the requirements. The bench also samples just before the edge, which shows that neither event takes effect early.

// File: rtl/irqen_pkg.sv
package irqen_pkg;

   // Order of the request levels inside the internal level vector.
   localparam int LVL_L14  = 0;
   localparam int LVL_L10  = 1;
   localparam int LVL_L6   = 2;
   localparam int LVL_SOFT = 3;
   localparam int NUM_LVL  = 4;

   // Kind of gating a level uses.
   typedef enum logic {
      GATE_SOFTWARE = 1'b0,
      GATE_TIMER    = 1'b1
   } gate_kind_e;

   function automatic gate_kind_e level_kind(input int lvl);
      return (lvl == LVL_L14 || lvl == LVL_L10) ? GATE_TIMER : GATE_SOFTWARE;
   endfunction

endpackage

// File: rtl/irqen_ctrl_reg.sv
module irqen_ctrl_reg #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctrl_q,
   output logic [REG_W-1:0] ctrl_nxt
);

   // Value the register holds after the coming edge; the level gates use it
   // so lines and byte move together.
   always_comb begin
      ctrl_nxt = wr_en ? wr_data : ctrl_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_nxt;
      end
   end

endmodule

// File: rtl/irqen_level_gate.sv
module irqen_level_gate #(
   parameter irqen_pkg::gate_kind_e KIND = irqen_pkg::GATE_TIMER,
   parameter int SRC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master_nxt,
   input  logic             enable_nxt,
   input  logic [SRC_W-1:0] src_flags,
   output logic             irq_q
);

   logic arm;

   generate
      if (KIND == irqen_pkg::GATE_TIMER) begin : g_timer
         assign arm = |src_flags;
      end else begin : g_software
         logic unused_src;
         assign unused_src = ^src_flags;
         assign arm = 1'b1;
      end
   endgenerate

   logic irq_d;
   assign irq_d = master_nxt & enable_nxt & arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= irq_d;
      end
   end

   // A raised line needs the master switch as seen at the previous edge.
   assert_irq_needs_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(master_nxt));

   // A raised line needs its own enable bit.
   assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(enable_nxt));

   generate
      if (KIND == irqen_pkg::GATE_TIMER) begin : g_timer_chk
         // R4 and R5: a timer line needs a flag of its pair.
         assert_timer_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q |-> $past(|src_flags));
      end
   endgenerate

endmodule

// File: rtl/tmr_irq_enable.sv
module tmr_irq_enable #(
   parameter int REG_W       = 8,
   parameter int NUM_TMR     = 4,
   parameter int MASTER_BIT  = 0,
   parameter int EN_BIT_L14  = 7,
   parameter int EN_BIT_L10  = 5,
   parameter int EN_BIT_L6   = 3,
   parameter int EN_BIT_SOFT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [NUM_TMR-1:0] tmr_flag,
   output logic [REG_W-1:0]   rd_data,
   output logic               irq_l14,
   output logic               irq_l10,
   output logic               irq_l6,
   output logic               irq_soft
);
   import irqen_pkg::*;

   localparam int TMR_PER_LVL = NUM_TMR / 2;
   localparam int LVL_EN [NUM_LVL] = '{EN_BIT_L14, EN_BIT_L10, EN_BIT_L6, EN_BIT_SOFT};

   // Elaboration-time parameter checks.
   generate
      if (NUM_TMR < 2 || (NUM_TMR % 2) != 0) begin : g_bad_tmr
         $error("tmr_irq_enable: NUM_TMR must be even and at least 2");
      end
      if (MASTER_BIT >= REG_W || EN_BIT_L14 >= REG_W || EN_BIT_L10 >= REG_W ||
          EN_BIT_L6 >= REG_W || EN_BIT_SOFT >= REG_W) begin : g_bad_pos
         $error("tmr_irq_enable: enable bit outside the register");
      end
      if (MASTER_BIT == EN_BIT_L14 || MASTER_BIT == EN_BIT_L10 || MASTER_BIT == EN_BIT_L6 ||
          MASTER_BIT == EN_BIT_SOFT || EN_BIT_L14 == EN_BIT_L10 || EN_BIT_L14 == EN_BIT_L6 ||
          EN_BIT_L14 == EN_BIT_SOFT || EN_BIT_L10 == EN_BIT_L6 || EN_BIT_L10 == EN_BIT_SOFT ||
          EN_BIT_L6 == EN_BIT_SOFT) begin : g_bad_dup
         $error("tmr_irq_enable: enable bits must be distinct");
      end
   endgenerate

   logic [REG_W-1:0]   ctrl_q;
   logic [REG_W-1:0]   ctrl_nxt;
   logic [NUM_LVL-1:0] lvl_q;

   irqen_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .ctrl_q   (ctrl_q),
      .ctrl_nxt (ctrl_nxt)
   );

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         logic [TMR_PER_LVL-1:0] src;
         if (l == LVL_L14) begin : g_hi_pair
            assign src = tmr_flag[NUM_TMR-1:TMR_PER_LVL];
         end else if (l == LVL_L10) begin : g_lo_pair
            assign src = tmr_flag[TMR_PER_LVL-1:0];
         end else begin : g_no_pair
            assign src = '0;
         end

         irqen_level_gate #(
            .KIND  (level_kind(l)),
            .SRC_W (TMR_PER_LVL)
         ) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .master_nxt (ctrl_nxt[MASTER_BIT]),
            .enable_nxt (ctrl_nxt[LVL_EN[l]]),
            .src_flags  (src),
            .irq_q      (lvl_q[l])
         );
      end
   endgenerate

   assign rd_data  = ctrl_q;
   assign irq_l14  = lvl_q[LVL_L14];
   assign irq_l10  = lvl_q[LVL_L10];
   assign irq_l6   = lvl_q[LVL_L6];
   assign irq_soft = lvl_q[LVL_SOFT];

   // With the stored master bit clear, the level register must be quiet.
   assert_master_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[MASTER_BIT] |-> (lvl_q == '0));

   // Software level agrees with the stored byte.
   assert_soft6_tracks_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_l6 == (ctrl_q[MASTER_BIT] && ctrl_q[EN_BIT_L6]));

   assert_soft_tracks_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_soft == (ctrl_q[MASTER_BIT] && ctrl_q[EN_BIT_SOFT]));

   // No write and steady flags: lines hold.
   assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && $stable(tmr_flag)) |=> $stable(lvl_q));

endmodule

// File: tb/tb_tmr_irq_enable.sv
`timescale 1ns/1ps
module tb_tmr_irq_enable;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [3:0] tmr_flag = 4'h0;
   logic [7:0] rd_data;
   logic       irq_l14, irq_l10, irq_l6, irq_soft;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   tmr_irq_enable dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .tmr_flag (tmr_flag),
      .rd_data  (rd_data),
      .irq_l14  (irq_l14),
      .irq_l10  (irq_l10),
      .irq_l6   (irq_l6),
      .irq_soft (irq_soft)
   );

   // Row layout: [24] write, [23:16] data, [15:12] flags, [11:8] lines {l14,l10,l6,soft}, [7:0] readback.
   localparam int NV = 16;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 8'h00, 4'h0, 4'b0000, 8'h00},
      {1'b1, 8'hAC, 4'hF, 4'b0000, 8'hAC},
      {1'b1, 8'hAD, 4'hF, 4'b1111, 8'hAD},
      {1'b0, 8'h00, 4'h0, 4'b0011, 8'hAD},
      {1'b0, 8'h00, 4'h4, 4'b1011, 8'hAD},
      {1'b0, 8'h00, 4'h8, 4'b1011, 8'hAD},
      {1'b0, 8'h00, 4'h1, 4'b0111, 8'hAD},
      {1'b0, 8'h00, 4'h2, 4'b0111, 8'hAD},
      {1'b1, 8'h8D, 4'h3, 4'b0011, 8'h8D},
      {1'b1, 8'h21, 4'h1, 4'b0100, 8'h21},
      {1'b1, 8'h52, 4'hF, 4'b0000, 8'h52},
      {1'b1, 8'h53, 4'hF, 4'b0000, 8'h53},
      {1'b1, 8'h09, 4'h0, 4'b0010, 8'h09},
      {1'b1, 8'h05, 4'h0, 4'b0001, 8'h05},
      {1'b1, 8'hFF, 4'hF, 4'b1111, 8'hFF},
      {1'b1, 8'hFE, 4'hF, 4'b0000, 8'hFE}
   };
   localparam string VTAG [NV] = '{
      "R1", "R3", "R8", "R9", "R4", "R4", "R5", "R5",
      "R4", "R5", "R10", "R10", "R6", "R7", "R2", "R3"
   };

   task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   function automatic logic [3:0] lines();
      return {irq_l14, irq_l10, irq_l6, irq_soft};
   endfunction

   initial begin : watchdog
      while (cycles < 5000) begin
         @(posedge clk);
         cycles++;
      end
      failures++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state.
      check8("R1", rd_data, 8'h00);
      check8("R1", {4'h0, lines()}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: drive at a negedge, judge one edge later.
      for (int i = 0; i < NV; i++) begin
         wr_en    = VEC[i][24];
         wr_data  = VEC[i][23:16];
         tmr_flag = VEC[i][15:12];
         @(negedge clk);
         check8(VTAG[i], {4'h0, lines()}, {4'h0, VEC[i][11:8]});
         check8(VTAG[i], rd_data, VEC[i][7:0]);
      end
      wr_en = 1'b0;

      // R8: nothing moves before the edge; everything moves at it.
      wr_en = 1'b1; wr_data = 8'hAD; tmr_flag = 4'hF;
      #1;
      check8("R8", {4'h0, lines()}, 8'h00);
      check8("R8", rd_data, 8'hFE);
      @(negedge clk);
      check8("R8", {4'h0, lines()}, 8'h0F);
      check8("R8", rd_data, 8'hAD);

      // R11: rewriting the same byte keeps every line steady.
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check8("R11", {4'h0, lines()}, 8'h0F);
      end
      wr_en = 1'b0;
      @(negedge clk);
      check8("R11", {4'h0, lines()}, 8'h0F);

      // R9: dropping every flag takes one edge to reach the timer lines.
      tmr_flag = 4'h0;
      #1;
      check8("R9", {4'h0, lines()}, 8'h0F);
      @(negedge clk);
      check8("R9", {4'h0, lines()}, 8'h03);

      // R9: raising one flag of the upper pair brings back level 14 only.
      tmr_flag = 4'h8;
      @(negedge clk);
      check8("R9", {4'h0, lines()}, 8'h0B);

      // R1: reset in the middle of activity.
      rst_n = 1'b0;
      #1;
      check8("R1", rd_data, 8'h00);
      check8("R1", {4'h0, lines()}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1", {4'h0, lines()}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule